// File: doc/BRIEF.md
# Circular Scroll Tile Fetch Address Generator

This block turns a beam position and a pair of vertical scroll registers into the two background RAM addresses that one tile needs. The background plane is a ring of 32 tile rows, each 32 bytes long. The first half of a row holds sixteen tile codes and the second half holds the sixteen matching attribute bytes. Because the ring wraps inside 1 KB, any scroll value always selects a legal row.

The scroll is split into two parts. The fine part is a pixel offset within a 16-pixel tile. The coarse part is a tile-row count. The beam line, counted upward from the bottom of the screen, is added to the combined scroll value. A carry out of the pixel part moves the lookup to the next tile row.

The addresses are combinational from the request cycle and go to a RAM with one cycle of read latency. One cycle after the RAM data comes back, the block presents, with a strobe:
- the 9-bit tile number,
- the two flip flags,
- the palette scheme,
- the pixel offsets inside the tile, already mirrored by the flip flags.

Top module: `scroll_tile_fetch`

## Requirements
- R1: The coarse scroll is `{scroll_hi, scroll_lo[7:4]}`, and the fine scroll is `scroll_lo[3:0]`. Only the low 5 bits of the coarse value affect the result.
- R2: The tile row is `(coarse + ((pix_y + fine) >> 4)) mod 32`. The column is `pix_x[7:4]`. `code_addr` is `row*32 + column`, combinational in the cycle `req` is high.
- R3: `attr_addr` equals `code_addr + 16`. This is the attribute byte of the same row and column.
- R4: With both scroll registers at zero, beam lines 0 to 15 address tile row 0, the first 32 bytes of the RAM.
- R5: The row index wraps inside the 1 KB ring. A coarse value of 32 addresses row 0, and row 31 plus one tile row addresses row 0 again.
- R6: `tile_num` is 9 bits. Its bit 8 is attribute bit 7, and its low byte is the code byte.
- R7: `flip_x` is attribute bit 6, `flip_y` is attribute bit 5, and `palette` is attribute bits 4:0.
- R8: `px_off_x` is `pix_x[3:0]`, inverted in all bits when `flip_x` is 1. `px_off_y` is `(pix_y + fine) mod 16`, inverted in all bits when `flip_y` is 1.
- R9: The RAM data is taken one cycle after `req`. `tile_vld` is high for exactly the cycle two clock edges after each `req` cycle, and at no other time.
- R10: While and after reset, with no request, `tile_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scroll_lo | input | 8 | Fine scroll (bits 3:0) and coarse low nibble (bits 7:4) |
| scroll_hi | input | 8 | Coarse scroll upper bits |
| pix_x | input | 8 | Beam column in pixels |
| pix_y | input | 9 | Beam line in pixels, 0 at the bottom of the screen |
| req | input | 1 | Start a lookup for the current position |
| code_addr | output | 10 | RAM address of the tile code |
| attr_addr | output | 10 | RAM address of the tile attribute |
| code_rd | input | 8 | Code byte from RAM, one cycle after `req` |
| attr_rd | input | 8 | Attribute byte from RAM, one cycle after `req` |
| tile_vld | output | 1 | Decoded outputs valid |
| tile_num | output | 9 | Tile number |
| flip_x | output | 1 | Horizontal mirror flag |
| flip_y | output | 1 | Vertical mirror flag |
| palette | output | 5 | Palette scheme |
| px_off_x | output | 4 | Pixel column inside the tile, after mirroring |
| px_off_y | output | 4 | Pixel line inside the tile, after mirroring |

## Verification
The bound checker checks, on every cycle:
- the strobe timing against `req`, two cycles later, in both directions;
- that the column field of the address follows the beam column;
- that the tile number, flip flags and palette match the RAM bytes from the previous cycle;
- that the mirrored horizontal offset matches the beam column captured two cycles earlier.

Only the bench scenarios can show the row arithmetic: the carry from fine scroll into the tile row, the use of the high scroll register, the zero-scroll bottom row and the wrap of the ring. These come from scroll and line values that the bench chooses and compares against a row computed on its own.

// File: rtl/scroll_tile_fetch.sv
module scroll_tile_fetch #(
  parameter int PX_W  = 4,
  parameter int COL_W = 4,
  parameter int ROW_W = 5,
  parameter int SCR_W = 8,
  parameter int DW    = 8,
  localparam int XW    = COL_W + PX_W,
  localparam int YW    = ROW_W + PX_W,
  localparam int AW    = ROW_W + COL_W + 1,
  localparam int PAL_W = DW - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SCR_W-1:0] scroll_lo,
  input  logic [SCR_W-1:0] scroll_hi,
  input  logic [XW-1:0]    pix_x,
  input  logic [YW-1:0]    pix_y,
  input  logic             req,
  output logic [AW-1:0]    code_addr,
  output logic [AW-1:0]    attr_addr,
  input  logic [DW-1:0]    code_rd,
  input  logic [DW-1:0]    attr_rd,
  output logic             tile_vld,
  output logic [DW:0]      tile_num,
  output logic             flip_x,
  output logic             flip_y,
  output logic [PAL_W-1:0] palette,
  output logic [PX_W-1:0]  px_off_x,
  output logic [PX_W-1:0]  px_off_y
);

  localparam int CRS_W = 2 * SCR_W - PX_W;

  logic [CRS_W-1:0] coarse;
  logic [YW-1:0]    line;
  logic             s1_vld;
  logic [PX_W-1:0]  s1_offx;
  logic [PX_W-1:0]  s1_offy;

  assign coarse    = {scroll_hi, scroll_lo[SCR_W-1:PX_W]};
  assign line      = {coarse[ROW_W-1:0], scroll_lo[PX_W-1:0]} + pix_y;
  assign code_addr = {line[YW-1:PX_W], 1'b0, pix_x[XW-1:PX_W]};
  assign attr_addr = {line[YW-1:PX_W], 1'b1, pix_x[XW-1:PX_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_offx <= '0;
      s1_offy <= '0;
    end else begin
      s1_vld  <= req;
      s1_offx <= pix_x[PX_W-1:0];
      s1_offy <= line[PX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_vld <= 1'b0;
      tile_num <= '0;
      flip_x   <= 1'b0;
      flip_y   <= 1'b0;
      palette  <= '0;
      px_off_x <= '0;
      px_off_y <= '0;
    end else begin
      tile_vld <= s1_vld;
      if (s1_vld) begin
        tile_num <= {attr_rd[DW-1], code_rd};
        flip_x   <= attr_rd[DW-2];
        flip_y   <= attr_rd[DW-3];
        palette  <= attr_rd[PAL_W-1:0];
        px_off_x <= s1_offx ^ {PX_W{attr_rd[DW-2]}};
        px_off_y <= s1_offy ^ {PX_W{attr_rd[DW-3]}};
      end
    end
  end

endmodule

// File: rtl/scroll_tile_fetch_chk.sv
module scroll_tile_fetch_chk #(
  parameter int PX_W  = 4,
  parameter int COL_W = 4,
  parameter int ROW_W = 5,
  parameter int DW    = 8,
  localparam int XW    = COL_W + PX_W,
  localparam int AW    = ROW_W + COL_W + 1,
  localparam int PAL_W = DW - 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [XW-1:0]    pix_x,
  input logic             req,
  input logic [AW-1:0]    code_addr,
  input logic [DW-1:0]    code_rd,
  input logic [DW-1:0]    attr_rd,
  input logic             tile_vld,
  input logic [DW:0]      tile_num,
  input logic             flip_x,
  input logic             flip_y,
  input logic [PAL_W-1:0] palette,
  input logic [PX_W-1:0]  px_off_x
);

  logic [PX_W-1:0] beam_fx;
  assign beam_fx = pix_x[PX_W-1:0];

  // R9
  vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ##2 tile_vld);

  // R9
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> ##2 !tile_vld);

  // R2
  column_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> code_addr[COL_W-1:0] == pix_x[XW-1:PX_W]);

  // R6
  tile_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_vld |-> tile_num == {$past(attr_rd[DW-1]), $past(code_rd)});

  // R7
  attr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_vld |-> (flip_x == $past(attr_rd[DW-2]) && flip_y == $past(attr_rd[DW-3])
                  && palette == $past(attr_rd[PAL_W-1:0])));

  // R8
  mirror_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_vld |-> px_off_x == ($past(beam_fx, 2) ^ {PX_W{flip_x}}));

endmodule

bind scroll_tile_fetch scroll_tile_fetch_chk #(
  .PX_W(PX_W), .COL_W(COL_W), .ROW_W(ROW_W), .DW(DW)
) u_chk (.*);

// File: tb/scroll_tile_fetch_tb.sv
module scroll_tile_fetch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] scroll_lo = '0, scroll_hi = '0;
  logic [7:0] pix_x = '0;
  logic [8:0] pix_y = '0;
  logic       req = 1'b0;
  logic [9:0] code_addr, attr_addr;
  logic [7:0] code_rd, attr_rd;
  logic       tile_vld, flip_x, flip_y;
  logic [8:0] tile_num;
  logic [4:0] palette;
  logic [3:0] px_off_x, px_off_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  scroll_tile_fetch u_dut (.*);

  logic [7:0] ram [0:1023];
  always @(posedge clk) begin
    code_rd <= ram[code_addr];
    attr_rd <= ram[attr_addr];
  end

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [23:0] exp_q[$];
  int          cyc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int sl, int sh, int px, int py, string tag);
    int fine, crs, ln, row, ca, aa, ox, oy;
    logic [7:0] cd, at;
    @(negedge clk);
    scroll_lo = 8'(sl); scroll_hi = 8'(sh); pix_x = 8'(px); pix_y = 9'(py); req = 1'b1;
    fine = sl % 16;
    crs  = sh * 16 + sl / 16;
    ln   = py + fine;
    row  = (crs + ln / 16) % 32;
    ca   = row * 32 + px / 16;
    aa   = ca + 16;
    #1;
    check(code_addr == 10'(ca), tag, "R2 code address", int'(code_addr), ca);
    check(attr_addr == 10'(aa), tag, "R3 attribute address", int'(attr_addr), aa);
    cd = ram[ca];
    at = ram[aa];
    ox = (px % 16) ^ (at[6] ? 15 : 0);
    oy = (ln % 16) ^ (at[5] ? 15 : 0);
    exp_q.push_back({at[7], cd, at[6], at[5], at[4:0], 4'(ox), 4'(oy)});
    cyc_q.push_back(cyc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tile_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "strobe without request", 1, 0);
      end else begin
        logic [23:0] e;
        int c;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        check(cyc == c + 2, "R9", "strobe cycle", cyc, c + 2);
        check(tile_num == e[23:15], "R6", "tile number", int'(tile_num), int'(e[23:15]));
        check({flip_x, flip_y, palette} == e[14:8], "R7", "flip/palette",
              int'({flip_x, flip_y, palette}), int'(e[14:8]));
        check({px_off_x, px_off_y} == e[7:0], "R8", "pixel offsets",
              int'({px_off_x, px_off_y}), int'(e[7:0]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s;
    for (int i = 0; i < 1024; i++) ram[i] = 8'((i * 73 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    check(tile_vld == 1'b0, "R10", "strobe during reset", int'(tile_vld), 0);
    rst_n = 1'b1;
    idle(3);
    check(tile_vld == 1'b0, "R10", "strobe after reset", int'(tile_vld), 0);

    for (int y = 0; y < 16; y++) apply(0, 0, y * 16 + y, y, "R4");
    apply(0, 0, 0, 16, "R4");
    idle(2);
    apply(8'h35, 0, 8'h47, 3, "R1");
    apply(8'h20, 1, 8'hF2, 0, "R1");
    apply(8'h0F, 0, 8'h10, 1, "R1");
    apply(8'h0F, 0, 8'h10, 0, "R1");
    idle(1);
    apply(8'h00, 2, 8'h33, 5, "R5");
    apply(8'hF0, 1, 8'h81, 16, "R5");
    apply(8'hFF, 8'hFF, 8'hFF, 9'h1FF, "R5");
    apply(8'h7A, 8'h03, 8'h5C, 9'h1F0, "R5");
    idle(3);
    s = 12345;
    for (int k = 0; k < 60; k++) begin
      s = (s * 1103515245 + 12345) & 32'h7FFFFFFF;
      apply((s >> 3) & 255, (s >> 11) & 255, (s >> 19) & 255, (s >> 5) & 511, "R2");
      if (k % 7 == 3) idle(k % 3 + 1);
    end
    idle(5);
    check(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    check(tile_vld == 1'b0, "R9", "strobe while idle", int'(tile_vld), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule